// File: doc/BRIEF.md
# Key Combination Reset Detector

This block watches four active-high key lines and raises a system reset request when a chosen group of them is held high together for long enough. A static two-bit select field picks the group: no keys (function off), the first two keys, the first three, or all four. The hold time is counted in pulses of a slow timebase enable, against a terminal count set by parameter. A user sets that count for a hold of one to three seconds, for example two seconds' worth of ticks.

An optional noise filter samples the keys on a 4 kHz strobe. It takes a new level only after two samples in a row agree. A bypass input routes the raw keys past the filter when fast response matters.

Once raised, the reset request stays high while the group is held. After release it stays high until one more timebase tick arrives. The request is ORed with an external power-on reset to form the system reset output.

Top module: `keycombo_reset_det`

## Requirements
- R1: `combo_sel` encodes the key group: 0 = none, 1 = keys 0 and 1, 2 = keys 0 to 2, 3 = keys 0 to 3; bit i of `key_raw` is key i.
- R2: With `combo_sel` = 0, no pattern on the key inputs ever raises `rst_req`.
- R3: The group qualifies only while every selected key is high at the same time; a partial group never raises `rst_req`.
- R4: `rst_req` rises in the cycle after the HOLD_TICKS-th `tick_en` pulse seen while the group is continuously qualified, and not after fewer pulses.
- R5: If any selected key drops low before the hold completes, the hold count returns to zero and a full HOLD_TICKS pulses are needed again.
- R6: With `filt_bypass` = 0, a key level reaches the detector only after two consecutive `sample_en` strobes sample the same level, so a one-sample glitch is rejected; with `filt_bypass` = 1 the raw keys are used directly.
- R7: Once high, `rst_req` stays high while the group is held; after release it stays high until the next `tick_en` pulse and is low in the cycle after that pulse.
- R8: Keys outside the selected group have no effect on the hold count or on `rst_req`.
- R9: `sys_rst` is high whenever `por_in` or `rst_req` is high; `rst_n` low clears the filter, the hold count and `rst_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_raw | input | 4 | Raw active-high key lines |
| sample_en | input | 1 | One-cycle 4 kHz filter sampling strobe |
| tick_en | input | 1 | One-cycle slow timebase pulse for the hold count |
| combo_sel | input | 2 | Static key group select (R1 encoding) |
| filt_bypass | input | 1 | 1 = use raw keys, 0 = use filtered keys |
| por_in | input | 1 | Power-on reset to merge |
| rst_req | output | 1 | Registered key reset request |
| sys_rst | output | 1 | Merged reset, por_in OR rst_req |

## Verification
With bypass on, the group match is combinational from the keys. `rst_req` therefore changes at the clock edge of the final qualifying `tick_en` pulse, or at the releasing tick. With the filter on, a sample strobe adds one edge before the match changes. The bench drives every strobe and key change on the falling edge. It samples `rst_req` on the falling edge right after the pulse that is due to move it, and again one pulse early to prove the count is exact. Release checks take one sample before the trailing tick and one after it.

// File: rtl/keyrst_pkg.sv
package keyrst_pkg;

  localparam int NKEYS = 4;
  localparam int SELW  = 2;

  typedef enum logic [1:0] {
    HS_IDLE   = 2'd0,
    HS_ACTIVE = 2'd1,
    HS_LINGER = 2'd2
  } hold_state_t;

  // Key group mask for a select code (R1)
  function automatic logic [NKEYS-1:0] group_mask(input logic [SELW-1:0] sel);
    logic [NKEYS-1:0] m;
    m = '0;
    for (int i = 0; i < NKEYS; i++) begin
      if (sel != '0 && i <= int'(sel)) m[i] = 1'b1;
    end
    return m;
  endfunction

  // All masked keys high, and a non-empty mask
  function automatic logic group_hit(input logic [NKEYS-1:0] keys,
                                     input logic [NKEYS-1:0] mask);
    return (mask != '0) && ((keys & mask) == mask);
  endfunction

  // Two-sample agreement: accept new sample when it equals the previous one
  function automatic logic agree(input logic sample_now, input logic sample_prev);
    return sample_now == sample_prev;
  endfunction

endpackage

// File: rtl/key_filter.sv
module key_filter
  import keyrst_pkg::*;
#(
  parameter int WIDTH = NKEYS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_en,
  input  logic             bypass,
  input  logic [WIDTH-1:0] raw,
  output logic [WIDTH-1:0] keys_out
);

  logic [WIDTH-1:0] samp_q;
  logic [WIDTH-1:0] filt_q;

  for (genvar g = 0; g < WIDTH; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        samp_q[g] <= 1'b0;
        filt_q[g] <= 1'b0;
      end else if (sample_en) begin
        samp_q[g] <= raw[g];
        if (agree(raw[g], samp_q[g])) filt_q[g] <= raw[g];
      end
    end

    // R6: a filtered level changes only on a strobe whose sample agreed with the previous one
    p_filter_agree_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(filt_q[g]) |-> ($past(sample_en) && ($past(raw[g]) == $past(samp_q[g]))));
  end

  assign keys_out = bypass ? raw : filt_q;

endmodule

// File: rtl/combo_match.sv
module combo_match
  import keyrst_pkg::*;
(
  input  logic [NKEYS-1:0] keys,
  input  logic [SELW-1:0]  sel,
  output logic             hit
);

  logic [NKEYS-1:0] mask;

  always_comb begin
    mask = group_mask(sel);
    hit  = group_hit(keys, mask);
  end

  // R2: a disabled select never matches
  always_comb begin
    if (sel == '0) p_disabled_nohit_r2: assert (!hit);
  end

endmodule

// File: rtl/hold_ctrl.sv
module hold_ctrl
  import keyrst_pkg::*;
#(
  parameter int HOLD_TICKS = 2048
) (
  input  logic clk,
  input  logic rst_n,
  input  logic match,
  input  logic tick_en,
  output logic req
);

  localparam int CNT_W = $clog2(HOLD_TICKS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_TICKS - 1);

  hold_state_t      st;
  logic [CNT_W-1:0] cnt;
  logic             hold_done;

  assign hold_done = match && tick_en && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= HS_IDLE;
      cnt <= '0;
    end else begin
      unique case (st)
        HS_IDLE: begin
          if (!match) cnt <= '0;
          else if (hold_done) begin
            st  <= HS_ACTIVE;
            cnt <= '0;
          end else if (tick_en) cnt <= cnt + 1'b1;
        end
        HS_ACTIVE: begin
          cnt <= '0;
          if (!match) st <= HS_LINGER;
        end
        HS_LINGER: begin
          cnt <= '0;
          if (match) st <= HS_ACTIVE;
          else if (tick_en) st <= HS_IDLE;
        end
        default: begin
          st  <= HS_IDLE;
          cnt <= '0;
        end
      endcase
    end
  end

  assign req = (st != HS_IDLE);

  // R4: count never passes its terminal value
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
  // R4: the request only rises on a qualified tick
  p_rise_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req) |-> ($past(tick_en) && $past(match)));
  // R5: losing the group clears the count
  p_clear_on_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !match |=> (cnt == '0));
  // R7: with no tick the request cannot fall
  p_linger_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !tick_en) |=> req);

endmodule

// File: rtl/keycombo_reset_det.sv
module keycombo_reset_det
  import keyrst_pkg::*;
#(
  parameter int HOLD_TICKS = 2048
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NKEYS-1:0] key_raw,
  input  logic             sample_en,
  input  logic             tick_en,
  input  logic [SELW-1:0]  combo_sel,
  input  logic             filt_bypass,
  input  logic             por_in,
  output logic             rst_req,
  output logic             sys_rst
);

  logic [NKEYS-1:0] keys_f;
  logic             grp_hit;

  key_filter #(.WIDTH(NKEYS)) u_filter (
    .clk      (clk),
    .rst_n    (rst_n),
    .sample_en(sample_en),
    .bypass   (filt_bypass),
    .raw      (key_raw),
    .keys_out (keys_f)
  );

  combo_match u_match (
    .keys(keys_f),
    .sel (combo_sel),
    .hit (grp_hit)
  );

  hold_ctrl #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .match  (grp_hit),
    .tick_en(tick_en),
    .req    (rst_req)
  );

  assign sys_rst = por_in | rst_req;

  // R2: while disabled, an idle request stays low
  p_disabled_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (combo_sel == '0 && !rst_req) |=> !rst_req);
  // R9: power-on reset always reaches the merged output
  always_comb begin
    if (por_in) p_por_merge_r9: assert (sys_rst);
  end

endmodule

// File: tb/keycombo_reset_det_tb_top.sv
module keycombo_reset_det_tb_top;

  localparam int HT = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] key_raw = '0;
  logic       sample_en = 1'b0;
  logic       tick_en = 1'b0;
  logic [1:0] combo_sel = '0;
  logic       filt_bypass = 1'b1;
  logic       por_in = 1'b0;
  logic       rst_req;
  logic       sys_rst;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  keycombo_reset_det #(.HOLD_TICKS(HT)) dut_i (
    .clk(clk), .rst_n(rst_n), .key_raw(key_raw), .sample_en(sample_en),
    .tick_en(tick_en), .combo_sel(combo_sel), .filt_bypass(filt_bypass),
    .por_in(por_in), .rst_req(rst_req), .sys_rst(sys_rst)
  );

  // {sel[1:0], keys[3:0], expected}
  localparam logic [6:0] VEC [12] = '{
    {2'd0, 4'hF, 1'b0},  // R2
    {2'd1, 4'h3, 1'b1},  // R1
    {2'd1, 4'h1, 1'b0},  // R3
    {2'd1, 4'h2, 1'b0},  // R3
    {2'd1, 4'hF, 1'b1},  // R8
    {2'd1, 4'hC, 1'b0},  // R8
    {2'd2, 4'h3, 1'b0},  // R3
    {2'd2, 4'h7, 1'b1},  // R1
    {2'd2, 4'hB, 1'b0},  // R3
    {2'd3, 4'h7, 1'b0},  // R3
    {2'd3, 4'hF, 1'b1},  // R1
    {2'd2, 4'hF, 1'b1}   // R8
  };

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic tick();
    tick_en = 1'b1;
    @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick();
      cyc(1);
    end
  endtask

  task automatic sample();
    sample_en = 1'b1;
    @(negedge clk);
    sample_en = 1'b0;
  endtask

  task automatic release_all();
    key_raw = '0;
    cyc(1);
    tick();
    cyc(1);
  endtask

  initial begin
    #400000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    cyc(3);
    check("R9 reset req", rst_req, 1'b0);
    check("R9 reset sys", sys_rst, 1'b0);
    rst_n = 1'b1;
    cyc(2);

    for (int v = 0; v < 12; v++) begin
      combo_sel = VEC[v][6:5];
      key_raw   = VEC[v][4:1];
      cyc(1);
      ticks(HT - 1);
      check("R4 early", rst_req, 1'b0);
      tick();
      check("R1 R3 R8 vector", rst_req, VEC[v][0]);
      check("R9 merge", sys_rst, VEC[v][0]);
      release_all();
      check("R7 cleared after release", rst_req, 1'b0);
    end

    // R7: held stays high, release lingers until the next tick
    combo_sel = 2'd1;
    key_raw = 4'h3;
    cyc(1);
    ticks(HT);
    check("R4 asserted", rst_req, 1'b1);
    ticks(3);
    check("R7 held", rst_req, 1'b1);
    key_raw = '0;
    cyc(3);
    check("R7 linger", rst_req, 1'b1);
    tick();
    check("R7 drop after tick", rst_req, 1'b0);

    // R5: dropping a key restarts the count
    key_raw = 4'h3;
    cyc(1);
    ticks(HT - 1);
    key_raw = 4'h1;
    cyc(1);
    key_raw = 4'h3;
    cyc(1);
    ticks(HT - 1);
    check("R5 restarted", rst_req, 1'b0);
    tick();
    check("R5 full hold", rst_req, 1'b1);
    release_all();

    // R8: toggling an unselected key mid-hold has no effect
    key_raw = 4'h3;
    cyc(1);
    ticks(HT - 2);
    key_raw = 4'hB;
    cyc(1);
    key_raw = 4'h7;
    tick();
    check("R8 unselected early", rst_req, 1'b0);
    cyc(1);
    tick();
    check("R8 unselected no reset of count", rst_req, 1'b1);
    release_all();

    // R6: filtered path, glitch rejected, stable level accepted
    filt_bypass = 1'b0;
    key_raw = 4'h3;
    sample();
    key_raw = 4'h0;
    sample();
    key_raw = 4'h3;
    sample();
    ticks(HT);
    check("R6 glitch rejected", rst_req, 1'b0);
    sample();
    ticks(HT);
    check("R6 accepted after two samples", rst_req, 1'b1);
    key_raw = 4'h0;
    ticks(2);
    check("R6 release unseen without samples", rst_req, 1'b1);
    sample();
    sample();
    cyc(1);
    tick();
    check("R6 R7 filtered release", rst_req, 1'b0);
    filt_bypass = 1'b1;

    // R9: power-on reset merge and rst_n clearing
    por_in = 1'b1;
    cyc(1);
    check("R9 por merge", sys_rst, 1'b1);
    check("R9 por not req", rst_req, 1'b0);
    por_in = 1'b0;
    key_raw = 4'h3;
    cyc(1);
    ticks(HT);
    check("R9 pre-reset req", rst_req, 1'b1);
    rst_n = 1'b0;
    cyc(1);
    check("R9 rst_n clears", rst_req, 1'b0);
    check("R9 rst_n clears sys", sys_rst, 1'b0);
    key_raw = '0;
    rst_n = 1'b1;
    cyc(2);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule